// File: doc/BRIEF.md
# Protected Configuration Register Bank

This block is a small, word-addressed bank of device configuration and status registers that sits on a simple read/write strobe bus. Each register applies its own write rule. Identification words are read-only and built from tie-off inputs. A revision field can be written once. A trim-error status field can be set once. A peripheral-hold register is plain read/write. A capture-mode register holds a mode field and a sticky lock bit.

Two of the registers are protected. A write to either of them takes effect only while the global `unlock_i` input is high. Otherwise the write is dropped without any indication. Reads return registered data one cycle after the read strobe. Unmapped addresses read as zero and ignore writes.

There are three synchronous, active-high reset inputs: power-on, external and system. The external-domain fields are cleared by power-on or external reset. The system-domain fields are cleared by any of the three.

Top module: `cfgbank_top`

## Requirements
- R1: Word 0 reads `{17'b0, variant_i[1:0], 2'b0, pkg_code_i[2:0], grade_i[1:0], 6'b0}`. Word 1 reads `{8'h06, part_num_i, 8'h05, 8'h00}`, with class 06h in bits 31:24 and family 05h in bits 15:8.
- R2: When `rd_en_i` is high at a clock edge, `rvalid_o` is high after that edge and `rdata_o` holds the word addressed at that edge.
- R3: The revision register (word 2, bits 15:0) is write-once. The first write after an external or power-on reset loads it, even if the data is zero. Every later write is ignored. A system reset neither clears the value nor rearms the write.
- R4: The trim status register (word 3, bits 15:0) is set-once. Writes of zero are ignored and do not use up the chance. The first nonzero write loads the value, for example 0x1 (correctable single-bit), 0x2 (uncorrectable double-bit) or 0x20 (trim timeout). All later writes are ignored until an external or power-on reset.
- R5: Words 4 and 5 are protected. A write to either changes nothing unless `unlock_i` is high in the same cycle.
- R6: The hold register (word 4, bits HOLD_W-1:0) is plain read/write. Its value drives `periph_hold_o`. Bits above HOLD_W read zero.
- R7: The capture-mode register (word 5) has a mode field in bits 1:0. `cap_protected_o` is 1 only when the mode is 01; the modes 00, 10 and 11 give 0.
- R8: Bit 15 of word 5 is a set-once lock. Writing a 1 sets it, and in that same write the mode field is also written. While the lock is 1, every write to word 5 is ignored. Only a reset clears the lock.
- R9: Reserved bits always read 0, whatever was written to them. Reads of words 6 and above return 0, and writes to them change no state.
- R10: Power-on reset clears every field. External reset clears words 2 to 5. System reset clears only words 4 and 5, together with the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| ext_i | input | 1 | External reset, synchronous, active high |
| sys_i | input | 1 | System reset, synchronous, active high |
| unlock_i | input | 1 | Protection release for words 4 and 5 |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after the strobe |
| part_num_i | input | 8 | Part number tie-off |
| pkg_code_i | input | 3 | Package code tie-off |
| grade_i | input | 2 | Qualification grade tie-off |
| variant_i | input | 2 | Feature variant tie-off |
| periph_hold_o | output | HOLD_W | Peripheral hold controls |
| cap_protected_o | output | 1 | Capture registers protected mode |

## Verification
The assertions take for granted that `rd_en_i` and `wr_en_i` are never both asserted at the same clock edge, and that the tie-off inputs stay constant. The assertions on stability after one-shot writes also assume that a reset is held for whole clock cycles.

The stimulus meets these conditions by construction. All strobes and data change on the falling edge, and only one transfer is in flight at a time. Resets are pulsed for two full cycles while the bus is idle. The tie-offs are set once at time zero.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  localparam int WORD_ID_LO = 0;
  localparam int WORD_ID_HI = 1;
  localparam int WORD_REV   = 2;
  localparam int WORD_TRIM  = 3;
  localparam int WORD_HOLD  = 4;
  localparam int WORD_CAP   = 5;
  localparam int NUM_WORDS  = 6;

  localparam logic [7:0] CLASS_ID  = 8'h06;
  localparam logic [7:0] FAMILY_ID = 8'h05;

  localparam logic [1:0] CAP_MODE_GUARDED = 2'b01;
endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode #(
  parameter int AW = 4,
  parameter int N  = 6
) (
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  sel_o
);
  for (genvar k = 0; k < N; k++) begin : g_sel
    assign sel_o[k] = (addr_i == AW'(k));
  end
endmodule

// File: rtl/cfgbank_once_reg.sv
module cfgbank_once_reg #(
  parameter int W            = 16,
  parameter bit NONZERO_ARMS = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] value_o
);
  logic         used_q;
  logic [W-1:0] val_q;
  logic         take;

  if (NONZERO_ARMS) begin : g_setonce
    assign take = wr_i & ~used_q & (|wdata_i);
  end else begin : g_wronce
    assign take = wr_i & ~used_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= 1'b0;
      val_q  <= '0;
    end else if (take) begin
      used_q <= 1'b1;
      val_q  <= wdata_i;
    end
  end

  assign value_o = val_q;

  // R3 / R4: once consumed, value holds until reset
  a_r3_r4_once_hold: assert property (@(posedge clk) disable iff (rst)
    used_q |=> $stable(val_q));
endmodule

// File: rtl/cfgbank_lockreg.sv
module cfgbank_lockreg #(
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              lock_wdata_i,
  input  logic [TYPE_W-1:0] type_wdata_i,
  output logic              lock_o,
  output logic [TYPE_W-1:0] type_o
);
  logic              lock_q;
  logic [TYPE_W-1:0] type_q;
  logic              take;

  assign take = wr_i & ~lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      type_q <= '0;
    end else if (take) begin
      type_q <= type_wdata_i;
      if (lock_wdata_i) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;
  assign type_o = type_q;

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  a_r8_frozen_type: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(type_q));
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
  import cfgbank_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 32,
  parameter int REV_W    = 16,
  parameter int TRIM_W   = 16,
  parameter int HOLD_W   = 8,
  parameter int LOCK_BIT = 15,
  parameter int TYPE_W   = 2
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              ext_i,
  input  logic              sys_i,
  input  logic              unlock_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  input  logic [7:0]        part_num_i,
  input  logic [2:0]        pkg_code_i,
  input  logic [1:0]        grade_i,
  input  logic [1:0]        variant_i,
  output logic [HOLD_W-1:0] periph_hold_o,
  output logic              cap_protected_o
);
  localparam int N = NUM_WORDS;

  logic rst_ext_dom, rst_sys_dom;
  assign rst_ext_dom = por_i | ext_i;
  assign rst_sys_dom = rst_ext_dom | sys_i;

  logic [N-1:0] sel;
  cfgbank_decode #(.AW(AW), .N(N)) u_dec (.addr_i(addr_i), .sel_o(sel));

  logic [N-1:0] wr_sel;
  assign wr_sel = {N{wr_en_i}} & sel;

  logic [REV_W-1:0]  rev_val;
  logic [TRIM_W-1:0] trim_val;

  cfgbank_once_reg #(.W(REV_W), .NONZERO_ARMS(1'b0)) u_rev (
    .clk(clk), .rst(rst_ext_dom), .wr_i(wr_sel[WORD_REV]),
    .wdata_i(wdata_i[REV_W-1:0]), .value_o(rev_val));

  cfgbank_once_reg #(.W(TRIM_W), .NONZERO_ARMS(1'b1)) u_trim (
    .clk(clk), .rst(rst_ext_dom), .wr_i(wr_sel[WORD_TRIM]),
    .wdata_i(wdata_i[TRIM_W-1:0]), .value_o(trim_val));

  logic [HOLD_W-1:0] hold_q;
  always_ff @(posedge clk) begin
    if (rst_sys_dom) hold_q <= '0;
    else if (wr_sel[WORD_HOLD] && unlock_i) hold_q <= wdata_i[HOLD_W-1:0];
  end
  assign periph_hold_o = hold_q;

  logic              cap_lock;
  logic [TYPE_W-1:0] cap_type;
  cfgbank_lockreg #(.TYPE_W(TYPE_W)) u_cap (
    .clk(clk), .rst(rst_sys_dom),
    .wr_i(wr_sel[WORD_CAP] & unlock_i),
    .lock_wdata_i(wdata_i[LOCK_BIT]),
    .type_wdata_i(wdata_i[TYPE_W-1:0]),
    .lock_o(cap_lock), .type_o(cap_type));
  assign cap_protected_o = (cap_type == CAP_MODE_GUARDED);

  logic [DW-1:0] words [N];
  assign words[WORD_ID_LO] = DW'({17'b0, variant_i, 2'b0, pkg_code_i, grade_i, 6'b0});
  assign words[WORD_ID_HI] = DW'({CLASS_ID, part_num_i, FAMILY_ID, 8'h00});
  assign words[WORD_REV]   = DW'(rev_val);
  assign words[WORD_TRIM]  = DW'(trim_val);
  assign words[WORD_HOLD]  = DW'(hold_q);
  assign words[WORD_CAP]   = DW'({cap_lock, {(LOCK_BIT-TYPE_W){1'b0}}, cap_type});

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N; k++) begin
      if (sel[k]) rd_mux = words[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_sys_dom) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  a_r2_read_latency: assert property (@(posedge clk) disable iff (rst_sys_dom)
    rd_en_i |=> rvalid_o);
  a_r5_hold_guard: assert property (@(posedge clk) disable iff (rst_sys_dom)
    !unlock_i |=> $stable(hold_q));
  a_r5_cap_guard: assert property (@(posedge clk) disable iff (rst_sys_dom)
    !unlock_i |=> $stable(cap_type));
  a_r9_decode_onehot: assert property (@(posedge clk) disable iff (por_i)
    $onehot0(sel));
endmodule

// File: tb/cfgbank_top_test.sv
module cfgbank_top_test;
  logic        clk = 1'b0;
  logic        por_i = 1'b1, ext_i = 1'b0, sys_i = 1'b0, unlock_i = 1'b0;
  logic        rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rvalid_o;
  logic [7:0]  part_num_i = 8'hA7;
  logic [2:0]  pkg_code_i = 3'd5;
  logic [1:0]  grade_i = 2'd2;
  logic [1:0]  variant_i = 2'd1;
  logic [7:0]  periph_hold_o;
  logic        cap_protected_o;

  always #2.5 clk = ~clk;

  cfgbank_top uut (.*);

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pop expected word when read data appears
  always @(negedge clk) begin
    if (rvalid_o) begin
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R2: got unexpected rvalid data %h expected no read", rdata_o);
      end else begin
        chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic unl);
    @(negedge clk);
    addr_i = a; wdata_i = d; unlock_i = unl; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; unlock_i = 1'b0;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    if (which == 0) por_i = 1'b1; else if (which == 1) ext_i = 1'b1; else sys_i = 1'b1;
    repeat (2) @(negedge clk);
    por_i = 1'b0; ext_i = 1'b0; sys_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_i = 1'b0;
    // reset state, R10
    rd(4'd2, 32'h0, "R10 rev after por");
    rd(4'd3, 32'h0, "R10 trim after por");
    rd(4'd4, 32'h0, "R10 hold after por");
    rd(4'd5, 32'h0, "R10 cap after por");
    chk("R6 hold out after por", 32'(periph_hold_o), 32'h0);
    chk("R7 mode out after por", 32'(cap_protected_o), 32'h0);
    // R1 identification
    rd(4'd0, 32'h0000_2580, "R1 id lo");
    rd(4'd1, 32'h06A7_0500, "R1 id hi");
    // R9 unmapped
    rd(4'd7, 32'h0, "R9 unmapped 7");
    rd(4'd15, 32'h0, "R9 unmapped 15");
    // R3 write-once, R9 reserved upper bits
    wr(4'd2, 32'hFFFF_1234, 1'b0);
    rd(4'd2, 32'h0000_1234, "R3 first write loads, R9 upper zero");
    wr(4'd2, 32'h0000_BEEF, 1'b1);
    rd(4'd2, 32'h0000_1234, "R3 second write ignored");
    // R4 set-once
    wr(4'd3, 32'h0, 1'b0);
    rd(4'd3, 32'h0, "R4 zero write");
    wr(4'd3, 32'h20, 1'b0);
    rd(4'd3, 32'h20, "R4 first nonzero loads");
    wr(4'd3, 32'h2, 1'b0);
    rd(4'd3, 32'h20, "R4 later write ignored");
    // R5 / R6 hold register
    wr(4'd4, 32'hFF, 1'b0);
    rd(4'd4, 32'h0, "R5 hold write without unlock");
    chk("R5 hold out unchanged", 32'(periph_hold_o), 32'h0);
    wr(4'd4, 32'hFFFF_FFFF, 1'b1);
    rd(4'd4, 32'hFF, "R6 hold write, upper zero");
    chk("R6 hold out", 32'(periph_hold_o), 32'hFF);
    wr(4'd4, 32'h5A, 1'b1);
    rd(4'd4, 32'h5A, "R6 hold rewrite");
    // R5 / R7 / R8 capture-mode register
    wr(4'd5, 32'h1, 1'b0);
    rd(4'd5, 32'h0, "R5 cap write without unlock");
    chk("R5 mode out unchanged", 32'(cap_protected_o), 32'h0);
    wr(4'd5, 32'h1, 1'b1);
    rd(4'd5, 32'h1, "R7 mode 01");
    chk("R7 mode 01 guarded", 32'(cap_protected_o), 32'h1);
    wr(4'd5, 32'h2, 1'b1);
    chk("R7 mode 10 open", 32'(cap_protected_o), 32'h0);
    wr(4'd5, 32'h3, 1'b1);
    chk("R7 mode 11 open", 32'(cap_protected_o), 32'h0);
    wr(4'd5, 32'h7FFD, 1'b1);
    rd(4'd5, 32'h1, "R9 cap reserved bits zero");
    wr(4'd5, 32'h8001, 1'b1);
    rd(4'd5, 32'h8001, "R8 lock set with mode");
    wr(4'd5, 32'h2, 1'b1);
    rd(4'd5, 32'h8001, "R8 write ignored while locked");
    chk("R8 mode out held", 32'(cap_protected_o), 32'h1);
    // R9 write to unmapped address
    wr(4'd9, 32'hFFFF_FFFF, 1'b1);
    rd(4'd9, 32'h0, "R9 unmapped after write");
    rd(4'd4, 32'h5A, "R9 hold untouched");
    rd(4'd5, 32'h8001, "R9 cap untouched");
    // R10 system reset
    pulse(2);
    rd(4'd4, 32'h0, "R10 sys clears hold");
    rd(4'd5, 32'h0, "R10 sys clears cap and lock");
    rd(4'd2, 32'h1234, "R10 sys keeps rev");
    rd(4'd3, 32'h20, "R10 sys keeps trim");
    wr(4'd2, 32'h9999, 1'b0);
    rd(4'd2, 32'h1234, "R3 sys does not rearm");
    wr(4'd5, 32'h1, 1'b1);
    rd(4'd5, 32'h1, "R8 writable after reset");
    wr(4'd4, 32'h33, 1'b1);
    // R10 external reset
    pulse(1);
    rd(4'd2, 32'h0, "R10 ext clears rev");
    rd(4'd3, 32'h0, "R10 ext clears trim");
    rd(4'd4, 32'h0, "R10 ext clears hold");
    rd(4'd5, 32'h0, "R10 ext clears cap");
    wr(4'd2, 32'h0, 1'b0);
    wr(4'd2, 32'h55, 1'b0);
    rd(4'd2, 32'h0, "R3 zero write consumes");
    wr(4'd3, 32'h1, 1'b0);
    rd(4'd3, 32'h1, "R4 rearmed by ext");
    wr(4'd4, 32'h11, 1'b1);
    // R10 power-on reset
    pulse(0);
    rd(4'd3, 32'h0, "R10 por clears trim");
    rd(4'd4, 32'h0, "R10 por clears hold");
    rd(4'd0, 32'h0000_2580, "R1 id lo after por");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R2: got %0d pending reads expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule